// File: doc/BRIEF.md
# Debug Trace Array with Serial Dump and Load

This block is a small register-file memory that a chip can borrow for debug. In normal operation it is ordinary functional storage, read and written through a word-wide port. Switched to trace mode, it becomes an embedded logic analyser: every cycle with the capture strobe high writes the capture word (a bus transaction, a group of sampled signals) into the next entry, going round the array in a circle. A wrap flag records that old entries have been overwritten.

The array sits outside the scan chains, so its contents leave through a dedicated dump mode. A dump walks the recorded entries from the oldest to the newest and shifts each one out on a one-bit serial output, least significant bit first. A serial load mode works the other way: the debugger shifts bits in, and every complete word is written to the next entry, so that the array can be preloaded to test a hypothesis. While any debug mode is selected the functional port has no effect on the array. A mode change request is refused while a dump is running or a load word is half shifted in.

Top module: `dbg_trace_ram`

## Requirements
- R1: After synchronous reset the mode is functional (mode code 0), and the wrap flag, dump done flag, serial output and busy flag are all 0.
- R2: In functional mode (code 0) a write with enable and write strobe stores the word at the given address; a read with enable and no write strobe presents that address's word on the read data output one clock later.
- R3: In every mode other than functional, functional writes leave the array unchanged and functional reads leave the read data output unchanged.
- R4: Entering trace mode (code 1) restarts the write pointer at address 0; each cycle with the capture strobe high writes the capture word at the pointer and advances it, wrapping from DEPTH-1 to 0.
- R5: The wrap flag rises when the DEPTH-th word since entering trace or load mode is written, stays high until trace or load mode is entered again, and survives a change to dump or functional mode.
- R6: In dump mode (code 2) a start pulse dumps the recorded entries: without wrap, entries 0 up to the pointer minus one; with wrap, all DEPTH entries starting at the pointer. Each word takes DATA_W cycles, bit 0 first, and its first bit is on the serial output in the cycle after the start pulse.
- R7: The done flag rises in the cycle after the last bit of the dump and stays high until the next start pulse or mode change; a start with no recorded entries sets it in the next cycle without shifting.
- R8: In load mode (code 3) each cycle with the load strobe high shifts one serial input bit, bit 0 first; after DATA_W bits the word is written at the pointer (which restarts at 0 on entering load mode) and the pointer advances, so loaded words are dumped or read back in load order.
- R9: A mode change request is ignored, and the mode output keeps its value, while the busy output is high; busy is high during a dump and while a load word is partly shifted in.
- R10: Outside dump mode, and in dump mode when no dump is running, the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode change request strobe |
| mode_req | input | 2 | Requested mode: 0 functional, 1 trace, 2 dump, 3 load |
| mode_o | output | 2 | Current mode code |
| busy_o | output | 1 | Dump running or load word partly shifted |
| func_en | input | 1 | Functional access enable |
| func_we | input | 1 | Functional write strobe |
| func_addr | input | AW | Functional address |
| func_wdata | input | DATA_W | Functional write data |
| func_rdata | output | DATA_W | Functional read data, one cycle latency |
| trc_valid | input | 1 | Capture strobe |
| trc_data | input | DATA_W | Capture word |
| wrap_o | output | 1 | Oldest entries overwritten |
| dump_start | input | 1 | Start a dump |
| dump_tdo | output | 1 | Serial dump data |
| dump_done | output | 1 | Dump finished |
| load_valid | input | 1 | Serial load bit strobe |
| load_tdi | input | 1 | Serial load data |

## Verification
Functional accesses are driven from a table that writes every address in a scrambled order and reads them back, which separates address decoding faults from data faults. Trace capture is tried both short of the array size and beyond it, so the dump order tells apart a dump that starts at address 0 from one that starts at the oldest entry after wrap. An empty dump, a mode change attempted mid-dump and mid-load, and functional writes issued in dump mode separate the locking and blocking rules from the data path. Serially loaded words are read back both through the dump and through the functional port, which checks bit order in both directions.

// File: rtl/tbuf_pkg.sv
`timescale 1ns/1ps
package tbuf_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC  = 2'd0,
        MODE_TRACE = 2'd1,
        MODE_DUMP  = 2'd2,
        MODE_LOAD  = 2'd3
    } tbuf_mode_e;

    typedef struct packed {
        logic       chg;
        tbuf_mode_e mode;
    } mode_evt_t;

    // Modes whose entry restarts the write pointer and wrap flag.
    function automatic logic restarts_ptr(input tbuf_mode_e m);
        return (m == MODE_TRACE) || (m == MODE_LOAD);
    endfunction

endpackage

// File: rtl/tbuf_mode_ctrl.sv
`timescale 1ns/1ps
module tbuf_mode_ctrl
    import tbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_wr,
    input  logic [1:0] req_mode,
    input  logic       busy,
    output tbuf_mode_e mode,
    output mode_evt_t  evt
);

    always_comb begin
        evt.chg  = req_wr && !busy;
        evt.mode = tbuf_mode_e'(req_mode);
    end

    always_ff @(posedge clk) begin
        if (rst)          mode <= MODE_FUNC;
        else if (evt.chg) mode <= evt.mode;
    end

    // R9: no mode change while a dump or partial load is in flight
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode));

endmodule

// File: rtl/tbuf_mem.sv
`timescale 1ns/1ps
module tbuf_mem #(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 8,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/tbuf_dump_ser.sv
`timescale 1ns/1ps
module tbuf_dump_ser #(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int BW     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              clear,
    input  logic [AW:0]       entries,
    input  logic [AW-1:0]     first,
    output logic [AW-1:0]     rd_addr,
    input  logic [DATA_W-1:0] rd_word,
    output logic              tdo,
    output logic              active,
    output logic              done
);

    logic [BW-1:0] bit_q;
    logic [AW:0]   rem_q;
    logic          last_bit;

    assign last_bit = (bit_q == BW'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active  <= 1'b0;
            done    <= 1'b0;
            rd_addr <= '0;
            bit_q   <= '0;
            rem_q   <= '0;
        end else if (start && !active) begin
            active  <= (entries != '0);
            done    <= (entries == '0);
            rd_addr <= first;
            bit_q   <= '0;
            rem_q   <= entries;
        end else if (active) begin
            if (last_bit) begin
                bit_q   <= '0;
                rd_addr <= rd_addr + AW'(1);
                rem_q   <= rem_q - (AW+1)'(1);
                if (rem_q == (AW+1)'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end else begin
                bit_q <= bit_q + BW'(1);
            end
        end
    end

    assign tdo = active && rd_word[bit_q];

    // R7: a dump that ends on its own always reports done
    assert_done_on_end_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(active) && !$past(clear)) |-> done);

    // R6: a running dump never has the done flag up
    assert_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> !done);

endmodule

// File: rtl/tbuf_load_des.sv
`timescale 1ns/1ps
module tbuf_load_des #(
    parameter  int DATA_W = 16,
    localparam int BW     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              clear,
    input  logic              tdi,
    output logic              commit,
    output logic [DATA_W-1:0] word,
    output logic              partial
);

    logic [DATA_W-1:0] hold_q;
    logic [BW-1:0]     cnt_q;

    assign word    = {tdi, hold_q[DATA_W-1:1]};
    assign commit  = shift && (cnt_q == BW'(DATA_W - 1));
    assign partial = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hold_q <= '0;
            cnt_q  <= '0;
        end else if (shift) begin
            hold_q <= word;
            cnt_q  <= commit ? '0 : cnt_q + BW'(1);
        end
    end

    // R8: a committed word leaves no partial word behind
    assert_commit_empty_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> !partial);

endmodule

// File: rtl/dbg_trace_ram.sv
`timescale 1ns/1ps
module dbg_trace_ram
    import tbuf_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 8,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [1:0]        mode_req,
    output logic [1:0]        mode_o,
    output logic              busy_o,
    input  logic              func_en,
    input  logic              func_we,
    input  logic [AW-1:0]     func_addr,
    input  logic [DATA_W-1:0] func_wdata,
    output logic [DATA_W-1:0] func_rdata,
    input  logic              trc_valid,
    input  logic [DATA_W-1:0] trc_data,
    output logic              wrap_o,
    input  logic              dump_start,
    output logic              dump_tdo,
    output logic              dump_done,
    input  logic              load_valid,
    input  logic              load_tdi
);

    tbuf_mode_e        mode_q;
    mode_evt_t         evt;
    logic [AW-1:0]     wr_ptr_q;
    logic              wrap_q;
    logic              dump_active, ld_partial, ld_commit;
    logic [DATA_W-1:0] ld_word, func_word, dump_word;
    logic [AW-1:0]     dump_addr;
    logic [AW:0]       entries;
    logic [AW-1:0]     first_addr;
    logic              mem_we, trace_wr, ld_shift;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    assign busy_o = dump_active || ld_partial;
    assign mode_o = mode_q;
    assign wrap_o = wrap_q;

    tbuf_mode_ctrl u_mode (
        .clk(clk), .rst(rst), .req_wr(mode_wr), .req_mode(mode_req),
        .busy(busy_o), .mode(mode_q), .evt(evt)
    );

    assign trace_wr = (mode_q == MODE_TRACE) && trc_valid;
    assign ld_shift = (mode_q == MODE_LOAD) && load_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            wrap_q   <= 1'b0;
        end else if (evt.chg && restarts_ptr(evt.mode)) begin
            wr_ptr_q <= '0;
            wrap_q   <= 1'b0;
        end else if (trace_wr || ld_commit) begin
            wr_ptr_q <= wr_ptr_q + AW'(1);
            if (wr_ptr_q == AW'(DEPTH - 1)) wrap_q <= 1'b1;
        end
    end

    assign entries    = wrap_q ? (AW+1)'(DEPTH) : {1'b0, wr_ptr_q};
    assign first_addr = wrap_q ? wr_ptr_q : '0;

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = wr_ptr_q;
        mem_wdata = trc_data;
        unique case (mode_q)
            MODE_FUNC: begin
                mem_we    = func_en && func_we;
                mem_waddr = func_addr;
                mem_wdata = func_wdata;
            end
            MODE_TRACE: mem_we = trc_valid;
            MODE_LOAD: begin
                mem_we    = ld_commit;
                mem_wdata = ld_word;
            end
            MODE_DUMP: mem_we = 1'b0;
        endcase
    end

    tbuf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(func_addr), .rdata_a(func_word),
        .raddr_b(dump_addr), .rdata_b(dump_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            func_rdata <= '0;
        else if (mode_q == MODE_FUNC && func_en && !func_we)
            func_rdata <= func_word;
    end

    tbuf_dump_ser #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dump (
        .clk(clk), .rst(rst),
        .start((mode_q == MODE_DUMP) && dump_start), .clear(evt.chg),
        .entries(entries), .first(first_addr), .rd_addr(dump_addr),
        .rd_word(dump_word), .tdo(dump_tdo), .active(dump_active),
        .done(dump_done)
    );

    tbuf_load_des #(.DATA_W(DATA_W)) u_load (
        .clk(clk), .rst(rst), .shift(ld_shift), .clear(evt.chg),
        .tdi(load_tdi), .commit(ld_commit), .word(ld_word),
        .partial(ld_partial)
    );

    // R5: wrap rises exactly when the last address has just been filled
    assert_wrap_point_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(wrap_q) |-> ($past(wr_ptr_q) == AW'(DEPTH - 1)));

    // R4: each capture advances the pointer by one
    assert_trace_step_R4: assert property (@(posedge clk) disable iff (rst)
        (trace_wr && !evt.chg) |=> (wr_ptr_q == $past(wr_ptr_q) + AW'(1)));

    // R10: serial output idle outside dump mode
    assert_tdo_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_DUMP) |-> !dump_tdo);

    // R3: read data frozen while the array is borrowed
    assert_func_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_FUNC) |=> $stable(func_rdata));

endmodule

// File: tb/dbg_trace_ram_tb_top.sv
`timescale 1ns/1ps
module dbg_trace_ram_tb_top;

    localparam int DW = 16;
    localparam int DEPTH = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_wr = 0, func_en = 0, func_we = 0, trc_valid = 0;
    logic dump_start = 0, load_valid = 0, load_tdi = 0;
    logic [1:0] mode_req = '0;
    logic [AW-1:0] func_addr = '0;
    logic [DW-1:0] func_wdata = '0, trc_data = '0;
    logic [1:0] mode_o;
    logic busy_o, wrap_o, dump_tdo, dump_done;
    logic [DW-1:0] func_rdata;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] got [DEPTH];
    logic [DW-1:0] rd;

    // {address, data}, all addresses in scrambled order
    localparam logic [AW+DW-1:0] FUNC_VEC [8] = '{
        {3'd5, 16'h5A5A}, {3'd0, 16'h0001}, {3'd7, 16'h8000}, {3'd2, 16'hFFFF},
        {3'd6, 16'h1234}, {3'd1, 16'hA5A5}, {3'd4, 16'h0F0F}, {3'd3, 16'hC3C3}
    };

    always #4 clk = ~clk; // 125 MHz

    dbg_trace_ram #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_req(mode_req),
        .mode_o(mode_o), .busy_o(busy_o), .func_en(func_en), .func_we(func_we),
        .func_addr(func_addr), .func_wdata(func_wdata), .func_rdata(func_rdata),
        .trc_valid(trc_valid), .trc_data(trc_data), .wrap_o(wrap_o),
        .dump_start(dump_start), .dump_tdo(dump_tdo), .dump_done(dump_done),
        .load_valid(load_valid), .load_tdi(load_tdi)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_req = m; mode_wr = 1'b1; tick(); mode_wr = 1'b0;
    endtask

    task automatic fwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        func_en = 1; func_we = 1; func_addr = a; func_wdata = d;
        tick(); func_en = 0; func_we = 0;
    endtask

    task automatic fread(input logic [AW-1:0] a, output logic [DW-1:0] d);
        func_en = 1; func_we = 0; func_addr = a;
        tick(); func_en = 0; d = func_rdata;
    endtask

    task automatic trace_push(input logic [DW-1:0] d);
        trc_valid = 1; trc_data = d; tick(); trc_valid = 0;
    endtask

    task automatic dump_collect(input int n);
        dump_start = 1; tick(); dump_start = 0;
        for (int w = 0; w < n; w++) begin
            for (int b = 0; b < DW; b++) begin
                got[w][b] = dump_tdo;
                tick();
            end
        end
    endtask

    task automatic load_bits(input logic [DW-1:0] w, input int lo, input int hi);
        for (int b = lo; b <= hi; b++) begin
            load_valid = 1; load_tdi = w[b]; tick();
        end
        load_valid = 0; load_tdi = 0;
    endtask

    function automatic logic [DW-1:0] tword(input int i);
        return 16'hB000 + DW'(i) * 16'h0123;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state, R10 idle serial output
        chk("R1 mode", mode_o, 0);
        chk("R1 wrap", wrap_o, 0);
        chk("R1 done", dump_done, 0);
        chk("R1 busy", busy_o, 0);
        chk("R10 tdo after reset", dump_tdo, 0);

        // R2 table-driven functional writes then reads
        for (int i = 0; i < 8; i++) begin
            fwrite(FUNC_VEC[i][AW+DW-1:DW], FUNC_VEC[i][DW-1:0]);
            model[FUNC_VEC[i][AW+DW-1:DW]] = FUNC_VEC[i][DW-1:0];
        end
        for (int i = 0; i < 8; i++) begin
            fread(FUNC_VEC[i][AW+DW-1:DW], rd);
            chk("R2 functional readback", rd, FUNC_VEC[i][DW-1:0]);
        end

        // R3 functional port blocked in dump mode
        set_mode(2);
        chk("R3 mode is dump", mode_o, 2);
        fwrite(3, 16'hDEAD);
        fread(6, rd);
        chk("R3 read data held", rd, model[3]);
        set_mode(0);
        fread(3, rd);
        chk("R3 blocked write left array", rd, model[3]);

        // R4/R6 short trace, dump from address 0
        set_mode(1);
        for (int i = 0; i < 3; i++) trace_push(16'hA100 + DW'(i));
        chk("R5 no wrap on short trace", wrap_o, 0);
        set_mode(2);
        chk("R10 tdo idle before start", dump_tdo, 0);
        dump_collect(3);
        for (int i = 0; i < 3; i++) chk("R6 short dump word", got[i], 16'hA100 + DW'(i));
        chk("R7 done after last bit", dump_done, 1);
        chk("R7 busy clear after dump", busy_o, 0);

        // R9 mode change refused during a dump
        dump_start = 1; tick(); dump_start = 0;
        chk("R9 busy during dump", busy_o, 1);
        set_mode(0);
        chk("R9 mode held in dump", mode_o, 2);
        chk("R7 done cleared by start", dump_done, 0);
        for (int i = 0; i < 200 && !dump_done; i++) tick();
        chk("R7 done after second dump", dump_done, 1);
        set_mode(0);
        chk("R7 done cleared by mode change", dump_done, 0);
        for (int i = 0; i < 3; i++) begin
            fread(AW'(i), rd);
            chk("R4 captured word at address", rd, 16'hA100 + DW'(i));
        end

        // R5/R6 wrapped trace, dump from oldest entry
        set_mode(1);
        for (int i = 0; i < 11; i++) begin
            trace_push(tword(i));
            if (i == 6) chk("R5 wrap low before full", wrap_o, 0);
            if (i == 7) chk("R5 wrap on DEPTH-th word", wrap_o, 1);
        end
        set_mode(2);
        dump_collect(8);
        for (int i = 0; i < 8; i++) chk("R6 wrapped dump order", got[i], tword(i + 3));
        chk("R5 wrap sticky after dump", wrap_o, 1);

        // R7 empty dump
        set_mode(1);
        chk("R5 wrap cleared on trace entry", wrap_o, 0);
        set_mode(2);
        dump_start = 1; tick(); dump_start = 0;
        chk("R7 empty dump done at once", dump_done, 1);
        chk("R7 empty dump not busy", busy_o, 0);
        chk("R10 tdo idle on empty dump", dump_tdo, 0);

        // R8 serial load, R9 refused mid-word
        set_mode(3);
        load_bits(16'h3C96, 0, 4);
        chk("R9 busy with partial word", busy_o, 1);
        set_mode(0);
        chk("R9 mode held in load", mode_o, 3);
        load_bits(16'h3C96, 5, DW - 1);
        load_bits(16'h8421, 0, DW - 1);
        chk("R8 no partial after full words", busy_o, 0);
        set_mode(2);
        dump_collect(2);
        chk("R8 loaded word 0 dumped", got[0], 16'h3C96);
        chk("R8 loaded word 1 dumped", got[1], 16'h8421);
        set_mode(0);
        fread(0, rd);
        chk("R8 loaded word 0 read", rd, 16'h3C96);
        fread(1, rd);
        chk("R8 loaded word 1 read", rd, 16'h8421);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule